// File: doc/BRIEF.md
# Parameter Commit Handshake Bank

This block sits between a host and a control loop. It holds two copies of the loop's tuning parameters. The host can write the shadow copy at any time. The loop only ever reads the working copy. The parameters are:

- an 18-bit two's-complement setpoint;
- a proportional gain and an integral gain, each a 64-bit two's-complement fixed-point value with 21 integer bits and 43 fraction bits;
- a 16-bit unsigned delay, counted in clock cycles, between loop iterations.

To publish a new set of values, the host raises a level request called change-request. The loop side grants the copy with an apply-ok strobe, typically between iterations. On the first granted cycle the block moves all four shadow values into the working copy in one clock edge and raises change-made. While change-request stays high, no further copy happens. Once the host sees change-made, it lowers change-request, and change-made then clears.

The block also registers two single-bit status paths: the host's run request, and the loop's in-loop indication. The control arithmetic itself lives outside this block.

Top module: `param_commit_bank`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, all four working outputs are zero, change_made is low, and run_req and in_loop are low. The shadow copy also clears to zero, so a commit with no writes since reset yields zeros.
- R2: A cycle with host_wr_en high writes one shadow field at the clock edge, chosen by host_wr_sel:
  - 0 selects the setpoint, taking host_wr_data[17:0];
  - 1 selects the proportional gain, taking host_wr_data[63:0];
  - 2 selects the integral gain, taking host_wr_data[63:0];
  - 3 selects the delay, taking host_wr_data[15:0].

  A shadow write alone never changes any working output.
- R3: A cycle with host_change_req high, loop_apply_ok high and change_made low is a commit. At that clock edge, all four working outputs take the shadow values together and change_made goes high.
- R4: While host_change_req stays high after a commit, no further copy happens, even if the shadow changes and loop_apply_ok is high. change_made stays high.
- R5: change_made is low starting on the clock edge at which host_change_req is sampled low. It is never high unless host_change_req was high on the previous edge.
- R6: If host_change_req falls before any commit, the working outputs do not change. loop_apply_ok with host_change_req low also copies nothing.
- R7: A shadow write in the same cycle as a commit is not part of that commit. The commit copies the value held before the write, and the new value waits for the next commit.
- R8: run_req and in_loop show host_run and loop_active as sampled at the previous clock edge.
- R9: While host_change_req is high and loop_apply_ok is low, no copy happens and change_made stays low. The copy happens on the first cycle in which loop_apply_ok is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Shadow write strobe |
| host_wr_sel | input | 2 | Shadow field select (0 setpoint, 1 P gain, 2 I gain, 3 delay) |
| host_wr_data | input | 64 | Shadow write data, low bits used for narrow fields |
| host_change_req | input | 1 | Level request to publish shadow values |
| host_run | input | 1 | Host run request |
| loop_apply_ok | input | 1 | Loop permits a parameter copy this cycle |
| loop_active | input | 1 | Loop reports that it is iterating |
| change_made | output | 1 | Copy done for the current request |
| run_req | output | 1 | Registered run request |
| in_loop | output | 1 | Registered in-loop status |
| wk_setpt | output | 18 | Working setpoint |
| wk_pgain | output | 64 | Working proportional gain |
| wk_igain | output | 64 | Working integral gain |
| wk_delay | output | 16 | Working inter-iteration delay |

## Verification
Directed sequences cover the distinct handshake orderings:

- a request that waits on a late grant, which separates a level-triggered copy from one that needs both inputs in the same cycle;
- a request held high across shadow rewrites, which exposes a repeat copy;
- a request abandoned before the grant, which exposes a copy taken without the handshake;
- a write that lands on the commit edge, which tells old-value from new-value capture.

A long random stretch then mixes writes to all four fields with random request and grant levels. A bench model built from the requirements checks every output on every cycle, so the order in which fields are written cannot hide a wrong field select or a split update.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic [1:0] {
    SEL_SETPT = 2'd0,
    SEL_PGAIN = 2'd1,
    SEL_IGAIN = 2'd2,
    SEL_DELAY = 2'd3
  } pcb_sel_e;

  typedef enum logic {
    HS_OPEN = 1'b0,
    HS_DONE = 1'b1
  } pcb_hs_e;

  localparam int SEL_W    = 2;
  localparam int NUM_GAIN = 2;

endpackage

// File: rtl/pcb_shadow.sv
module pcb_shadow
  import pcb_pkg::*;
#(
  parameter int SP_W   = 18,
  parameter int GAIN_W = 64,
  parameter int DLY_W  = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SP_W-1:0]   sh_setpt,
  output logic [GAIN_W-1:0] sh_pgain,
  output logic [GAIN_W-1:0] sh_igain,
  output logic [DLY_W-1:0]  sh_delay
);

  function automatic logic [SP_W-1:0] fit_setpt(input logic [DATA_W-1:0] d);
    return d[SP_W-1:0];
  endfunction

  function automatic logic [DLY_W-1:0] fit_delay(input logic [DATA_W-1:0] d);
    return d[DLY_W-1:0];
  endfunction

  function automatic logic [SEL_W-1:0] gain_sel(input int idx);
    return (idx == 0) ? SEL_W'(SEL_PGAIN) : SEL_W'(SEL_IGAIN);
  endfunction

  logic wr_setpt, wr_delay;
  assign wr_setpt = wr_en && (wr_sel == SEL_W'(SEL_SETPT));
  assign wr_delay = wr_en && (wr_sel == SEL_W'(SEL_DELAY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_setpt <= '0;
    end else if (wr_setpt) begin
      sh_setpt <= fit_setpt(wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_delay <= '0;
    end else if (wr_delay) begin
      sh_delay <= fit_delay(wr_data);
    end
  end

  logic [GAIN_W-1:0] gain_q [NUM_GAIN];

  for (genvar g = 0; g < NUM_GAIN; g++) begin : g_gain
    logic wr_this;
    assign wr_this = wr_en && (wr_sel == gain_sel(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_q[g] <= '0;
      end else if (wr_this) begin
        gain_q[g] <= wr_data[GAIN_W-1:0];
      end
    end
  end

  assign sh_pgain = gain_q[0];
  assign sh_igain = gain_q[1];

  AST_SHADOW_SETPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setpt |=> sh_setpt == $past(wr_data[SP_W-1:0])); // R2
  AST_SHADOW_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_delay |=> $stable(sh_delay)); // R2

endmodule

// File: rtl/pcb_handshake.sv
module pcb_handshake
  import pcb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic change_req,
  input  logic apply_ok,
  output logic commit,
  output logic change_made
);

  pcb_hs_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    commit  = 1'b0;
    unique case (state_q)
      HS_OPEN: begin
        if (change_req && apply_ok) begin
          commit  = 1'b1;
          state_d = HS_DONE;
        end
      end
      HS_DONE: begin
        if (!change_req) state_d = HS_OPEN;
      end
      default: state_d = HS_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_OPEN;
    else        state_q <= state_d;
  end

  assign change_made = (state_q == HS_DONE);

  AST_COMMIT_RAISES_MADE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> change_made); // R3
  AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    change_made |-> !commit); // R4
  AST_MADE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !change_req |=> !change_made); // R5
  AST_MADE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    change_made |-> $past(change_req)); // R5
  AST_WAIT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (change_req && !apply_ok && !change_made) |=> !change_made); // R9

endmodule

// File: rtl/pcb_work.sv
module pcb_work #(
  parameter int SP_W   = 18,
  parameter int GAIN_W = 64,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [SP_W-1:0]   sh_setpt,
  input  logic [GAIN_W-1:0] sh_pgain,
  input  logic [GAIN_W-1:0] sh_igain,
  input  logic [DLY_W-1:0]  sh_delay,
  output logic [SP_W-1:0]   wk_setpt,
  output logic [GAIN_W-1:0] wk_pgain,
  output logic [GAIN_W-1:0] wk_igain,
  output logic [DLY_W-1:0]  wk_delay
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_setpt <= '0;
      wk_pgain <= '0;
      wk_igain <= '0;
      wk_delay <= '0;
    end else if (commit) begin
      wk_setpt <= sh_setpt;
      wk_pgain <= sh_pgain;
      wk_igain <= sh_igain;
      wk_delay <= sh_delay;
    end
  end

  AST_WORK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (wk_pgain == $past(sh_pgain)) && (wk_setpt == $past(sh_setpt))
               && (wk_igain == $past(sh_igain)) && (wk_delay == $past(sh_delay))); // R3
  AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(wk_setpt) && $stable(wk_pgain)
                && $stable(wk_igain) && $stable(wk_delay)); // R6

endmodule

// File: rtl/pcb_status.sv
module pcb_status (
  input  logic clk,
  input  logic rst_n,
  input  logic host_run,
  input  logic loop_active,
  output logic run_req,
  output logic in_loop
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req <= 1'b0;
      in_loop <= 1'b0;
    end else begin
      run_req <= host_run;
      in_loop <= loop_active;
    end
  end

  AST_RUN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    host_run |=> run_req); // R8
  AST_LOOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_active |=> !in_loop); // R8

endmodule

// File: rtl/param_commit_bank.sv
module param_commit_bank
  import pcb_pkg::*;
#(
  parameter int SP_W   = 18,
  parameter int GAIN_W = 64,
  parameter int DLY_W  = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [1:0]        host_wr_sel,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_change_req,
  input  logic              host_run,
  input  logic              loop_apply_ok,
  input  logic              loop_active,
  output logic              change_made,
  output logic              run_req,
  output logic              in_loop,
  output logic [SP_W-1:0]   wk_setpt,
  output logic [GAIN_W-1:0] wk_pgain,
  output logic [GAIN_W-1:0] wk_igain,
  output logic [DLY_W-1:0]  wk_delay
);

  logic [SP_W-1:0]   sh_setpt;
  logic [GAIN_W-1:0] sh_pgain;
  logic [GAIN_W-1:0] sh_igain;
  logic [DLY_W-1:0]  sh_delay;
  logic              commit;

  pcb_shadow #(
    .SP_W(SP_W), .GAIN_W(GAIN_W), .DLY_W(DLY_W), .DATA_W(DATA_W)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr_en),
    .wr_sel   (host_wr_sel),
    .wr_data  (host_wr_data),
    .sh_setpt (sh_setpt),
    .sh_pgain (sh_pgain),
    .sh_igain (sh_igain),
    .sh_delay (sh_delay)
  );

  pcb_handshake u_hs (
    .clk         (clk),
    .rst_n       (rst_n),
    .change_req  (host_change_req),
    .apply_ok    (loop_apply_ok),
    .commit      (commit),
    .change_made (change_made)
  );

  pcb_work #(
    .SP_W(SP_W), .GAIN_W(GAIN_W), .DLY_W(DLY_W)
  ) u_work (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .sh_setpt (sh_setpt),
    .sh_pgain (sh_pgain),
    .sh_igain (sh_igain),
    .sh_delay (sh_delay),
    .wk_setpt (wk_setpt),
    .wk_pgain (wk_pgain),
    .wk_igain (wk_igain),
    .wk_delay (wk_delay)
  );

  pcb_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_run    (host_run),
    .loop_active (loop_active),
    .run_req     (run_req),
    .in_loop     (in_loop)
  );

  AST_MADE_NEEDS_PRIOR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(change_made) |-> $past(host_change_req) && $past(loop_apply_ok)); // R3
  AST_HOST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_change_req || change_made) |=> $stable(wk_pgain) && $stable(wk_setpt)); // R4

endmodule

// File: tb/param_commit_bank_test.sv
module param_commit_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [1:0]  host_wr_sel = 2'd0;
  logic [63:0] host_wr_data = '0;
  logic        host_change_req = 1'b0;
  logic        host_run = 1'b0;
  logic        loop_apply_ok = 1'b0;
  logic        loop_active = 1'b0;
  logic        change_made, run_req, in_loop;
  logic [17:0] wk_setpt;
  logic [63:0] wk_pgain, wk_igain;
  logic [15:0] wk_delay;

  always #2 clk = ~clk;

  param_commit_bank uut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel),
    .host_wr_data(host_wr_data), .host_change_req(host_change_req),
    .host_run(host_run), .loop_apply_ok(loop_apply_ok), .loop_active(loop_active),
    .change_made(change_made), .run_req(run_req), .in_loop(in_loop),
    .wk_setpt(wk_setpt), .wk_pgain(wk_pgain), .wk_igain(wk_igain), .wk_delay(wk_delay)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] m_sh [4];
  logic [63:0] m_wk [4];
  logic        m_made;

  function automatic logic [63:0] field_mask(input int sel);
    case (sel)
      0:       return (64'd1 << 18) - 64'd1;
      3:       return 64'h0000_0000_0000_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic [63:0] field_out(input int sel);
    case (sel)
      0:       return {46'd0, wk_setpt};
      1:       return wk_pgain;
      2:       return wk_igain;
      default: return {48'd0, wk_delay};
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 4; i++) check(tag, field_out(i), m_wk[i]);
    check(tag, {63'd0, change_made}, {63'd0, m_made});
  endtask

  // one clock: model predicts from inputs held across the edge
  task automatic tick();
    logic commit;
    logic [63:0] nsh [4];
    commit = host_change_req && loop_apply_ok && !m_made;
    for (int i = 0; i < 4; i++) nsh[i] = m_sh[i];
    if (host_wr_en) nsh[host_wr_sel] = host_wr_data & field_mask(int'(host_wr_sel));
    @(posedge clk);
    #1;
    if (commit) for (int i = 0; i < 4; i++) m_wk[i] = m_sh[i];
    if (commit) m_made = 1'b1;
    else if (!host_change_req) m_made = 1'b0;
    for (int i = 0; i < 4; i++) m_sh[i] = nsh[i];
  endtask

  task automatic write_field(input int sel, input logic [63:0] d);
    host_wr_en = 1'b1; host_wr_sel = 2'(sel); host_wr_data = d;
    tick();
    host_wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin m_sh[i] = '0; m_wk[i] = '0; end
    m_made = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 during reset");
    rst_n = 1'b1;
    tick();
    check_all("R1 after reset");
    check("R1 run_req", {63'd0, run_req}, 64'd0);
    check("R1 in_loop", {63'd0, in_loop}, 64'd0);

    // R2: shadow writes, working untouched; setpoint truncation to 18 bits
    write_field(0, 64'hFFFF_FFFF_FFFE_0001);
    write_field(1, 64'h0000_1234_5678_9ABC);
    write_field(2, 64'hFFFF_8000_0000_0001);
    write_field(3, 64'hDEAD_BEEF_0000_C350);
    check_all("R2 shadow only");

    // R9: request without grant waits
    host_change_req = 1'b1;
    repeat (3) tick();
    check_all("R9 waiting for grant");
    check("R9 made low", {63'd0, change_made}, 64'd0);
    loop_apply_ok = 1'b1;
    tick();
    check_all("R3 commit");
    check("R3 setpt value", {46'd0, wk_setpt}, 64'h0000_0000_0002_0001);
    check("R3 delay value", {48'd0, wk_delay}, 64'h0000_0000_0000_C350);

    // R4: held request, new shadow, grant high: no second copy
    write_field(1, 64'h1111_2222_3333_4444);
    repeat (3) tick();
    check_all("R4 no repeat copy");
    check("R4 pgain held", wk_pgain, 64'h0000_1234_5678_9ABC);

    // R5: drop request, change_made falls on that edge
    host_change_req = 1'b0;
    tick();
    check("R5 made falls", {63'd0, change_made}, 64'd0);
    check_all("R5 after drop");

    // R6: abandoned request, then grant with request low
    loop_apply_ok = 1'b0;
    host_change_req = 1'b1;
    tick();
    host_change_req = 1'b0;
    tick();
    loop_apply_ok = 1'b1;
    repeat (2) tick();
    check_all("R6 no update");
    check("R6 pgain old", wk_pgain, 64'h0000_1234_5678_9ABC);

    // R7: write during commit edge
    host_change_req = 1'b1;
    host_wr_en = 1'b1; host_wr_sel = 2'd0; host_wr_data = 64'h0000_0000_0000_0155;
    tick();
    host_wr_en = 1'b0;
    check("R7 old setpt copied", {46'd0, wk_setpt}, 64'h0000_0000_0002_0001);
    check_all("R7 commit");
    host_change_req = 1'b0;
    tick();
    host_change_req = 1'b1;
    tick();
    check("R7 new setpt next commit", {46'd0, wk_setpt}, 64'h0000_0000_0000_0155);
    host_change_req = 1'b0;
    loop_apply_ok = 1'b0;
    tick();

    // R8: status paths
    host_run = 1'b1; loop_active = 1'b0;
    tick();
    check("R8 run_req", {63'd0, run_req}, 64'd1);
    check("R8 in_loop", {63'd0, in_loop}, 64'd0);
    host_run = 1'b0; loop_active = 1'b1;
    tick();
    check("R8 run_req low", {63'd0, run_req}, 64'd0);
    check("R8 in_loop high", {63'd0, in_loop}, 64'd1);

    // random mix: R3 R4 R5 R6 R7 R9 against model
    for (int n = 0; n < 3000; n++) begin
      logic exp_run, exp_act;
      host_wr_en      = ($urandom % 3) == 0;
      host_wr_sel     = 2'($urandom % 4);
      host_wr_data    = {$urandom, $urandom};
      host_change_req = ($urandom % 4) != 0 ? host_change_req : ~host_change_req;
      loop_apply_ok   = ($urandom % 3) == 0;
      host_run        = 1'($urandom);
      loop_active     = 1'($urandom);
      exp_run = host_run; exp_act = loop_active;
      tick();
      check_all("R3 random");
      check("R8 random run", {63'd0, run_req}, {63'd0, exp_run});
      check("R8 random loop", {63'd0, in_loop}, {63'd0, exp_act});
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule